// File: doc/BRIEF.md
# Interprocessor Interrupt Target Selector

This block decides which processor agents an interprocessor interrupt request should reach. A request carries an 8-bit destination, a flag choosing physical or logical addressing, a 2-bit shorthand code, the sending agent's index and a lowest-priority flag. Each agent also supplies its own logical ID, its logical format model and an enable bit. The block combines these into an N-bit target mask, with bit i standing for agent i. Agent i's physical ID is its index.

In logical mode, each receiving agent picks its own matching rule from its format model. A flat agent matches on any shared bit between the destination and its logical ID. A cluster agent matches when the high nibbles are equal and the low nibbles overlap. A non-zero shorthand overrides the address decode entirely. Disabled agents are then removed from the mask.

For lowest-priority requests, the block narrows the mask to the lowest-numbered surviving agent. The result is registered on the clock edge that samples the request strobe. It stays held until the next request, and a flag marks an empty result.

Top module: `ipi_dest_match`

## Requirements
- R1: In physical mode with shorthand 0, destination 0xFF selects every agent.
- R2: In physical mode with shorthand 0, any destination other than 0xFF selects only the agent whose index equals it, and nothing when no index equals it.
- R3: In logical mode with shorthand 0, an agent with format model 4'hF (flat) is selected when destination AND its logical ID is non-zero.
- R4: In logical mode with shorthand 0, an agent with format model 4'h0 (cluster) is selected when destination[7:4] equals its logical ID[7:4] and destination[3:0] AND logical ID[3:0] is non-zero.
- R5: In logical mode, an agent whose format model is neither 4'hF nor 4'h0 is never selected by the address decode.
- R6: Shorthand 1 selects only the agent whose index equals the sender index, and selects nothing if the sender index is not below the agent count.
- R7: Shorthand 2 selects every agent, whatever the destination and mode.
- R8: Shorthand 3 selects every agent except the one whose index equals the sender index.
- R9: When the lowest-priority flag is set, the mask holds only the lowest-numbered bit that survives R1 to R8 and R10, or no bit at all.
- R10: An agent whose enable bit is low at request time never appears in the mask.
- R11: When a result is delivered, the no-target flag is 1 exactly when the mask is all zero.
- R12: The mask and flag update on the clock edge that samples req_valid. tgt_valid is high for exactly the cycle after each sampled request. Without a request, the outputs hold their values.
- R13: A synchronous reset clears tgt_valid, tgt_mask and tgt_none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_dest | input | ID_W | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 use destination, 1 self, 2 all, 3 all but sender |
| req_lowest | input | 1 | Lowest-priority delivery: pick one agent |
| sender_id | input | ID_W | Index of the sending agent |
| agent_en | input | AGENTS | Per-agent enable |
| agent_lid | input | AGENTS*ID_W | Logical ID of each agent, agent i at [i*ID_W +: ID_W] |
| agent_model | input | AGENTS*4 | Format model of each agent, agent i at [i*4 +: 4] |
| tgt_valid | output | 1 | Result delivered this cycle |
| tgt_mask | output | AGENTS | Selected agents |
| tgt_none | output | 1 | Result mask is empty |

## Verification
The bench uses a fixed agent population that holds flat agents, cluster agents and one agent with an unsupported format model. Against it, the bench aims at destinations that catch rule mix-ups.

- Destination 0x33 hits flat and cluster agents together. A design that applied one rule to every agent would drop half of them.
- Destination 0x50 matches a cluster high nibble but has an empty low nibble. A design that compared only the high nibble would select that agent.
- Destination 0xF0 would hit the unsupported-model agent under a flat rule. That agent must stay unselected.

The bench also covers several other corners:
- an out-of-range sender under the self shorthand;
- a shorthand that must override a logical destination;
- lowest-priority picks after enables have removed the lower agents, which a design that picks before masking would get wrong;
- an output that must hold while the inputs change with no strobe.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
  typedef enum logic [1:0] {
    SH_ADDR   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam int         MODEL_W       = 4;
endpackage

// File: rtl/ipi_logical_match.sv
module ipi_logical_match
  import ipi_dest_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0]    dest,
  input  logic [ID_W-1:0]    lid,
  input  logic [MODEL_W-1:0] model,
  output logic               hit
);
  localparam int HALF = ID_W / 2;

  logic flat_hit;
  logic clus_hit;

  always_comb begin
    flat_hit = |(dest & lid);
    clus_hit = (dest[ID_W-1:HALF] == lid[ID_W-1:HALF]) &&
               (|(dest[HALF-1:0] & lid[HALF-1:0]));
    unique case (model)
      MODEL_FLAT:    hit = flat_hit;
      MODEL_CLUSTER: hit = clus_hit;
      default:       hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_dest_pkg::*;
#(
  parameter int AGENTS = 8,
  parameter int ID_W   = 8
) (
  input  logic [ID_W-1:0]           dest,
  input  logic                      logical,
  input  logic [AGENTS*ID_W-1:0]    agent_lid,
  input  logic [AGENTS*MODEL_W-1:0] agent_model,
  output logic [AGENTS-1:0]         addr_mask
);
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  logic [AGENTS-1:0] log_hit;
  logic [AGENTS-1:0] phy_hit;

  for (genvar i = 0; i < AGENTS; i++) begin : g_agent
    ipi_logical_match #(.ID_W(ID_W)) match_i (
      .dest  (dest),
      .lid   (agent_lid[i*ID_W +: ID_W]),
      .model (agent_model[i*MODEL_W +: MODEL_W]),
      .hit   (log_hit[i])
    );
    assign phy_hit[i] = (dest == BCAST) || (dest == ID_W'(i));
  end

  assign addr_mask = logical ? log_hit : phy_hit;
endmodule

// File: rtl/ipi_shorthand_apply.sv
module ipi_shorthand_apply
  import ipi_dest_pkg::*;
#(
  parameter int AGENTS = 8,
  parameter int ID_W   = 8
) (
  input  logic [AGENTS-1:0] addr_mask,
  input  logic [1:0]        shorthand,
  input  logic [ID_W-1:0]   sender_id,
  input  logic [AGENTS-1:0] agent_en,
  output logic [AGENTS-1:0] sel_mask
);
  logic [AGENTS-1:0] self_bit;
  logic [AGENTS-1:0] raw;

  for (genvar i = 0; i < AGENTS; i++) begin : g_self
    assign self_bit[i] = (sender_id == ID_W'(i));
  end

  always_comb begin
    unique case (shorthand_e'(shorthand))
      SH_SELF:   raw = self_bit;
      SH_ALL:    raw = '1;
      SH_OTHERS: raw = ~self_bit;
      default:   raw = addr_mask;
    endcase
    sel_mask = raw & agent_en;
  end
endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
  parameter int AGENTS = 8
) (
  input  logic [AGENTS-1:0] mask_in,
  output logic [AGENTS-1:0] pick
);
  logic [AGENTS-1:0] seen;

  for (genvar i = 0; i < AGENTS; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign seen[i] = mask_in[i];
      assign pick[i] = mask_in[i];
    end else begin : g_rest
      assign seen[i] = seen[i-1] | mask_in[i];
      assign pick[i] = mask_in[i] & ~seen[i-1];
    end
  end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_dest_pkg::*;
#(
  parameter int AGENTS = 8,
  parameter int ID_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ID_W-1:0]           req_dest,
  input  logic                      req_logical,
  input  logic [1:0]                req_shorthand,
  input  logic                      req_lowest,
  input  logic [ID_W-1:0]           sender_id,
  input  logic [AGENTS-1:0]         agent_en,
  input  logic [AGENTS*ID_W-1:0]    agent_lid,
  input  logic [AGENTS*MODEL_W-1:0] agent_model,
  output logic                      tgt_valid,
  output logic [AGENTS-1:0]         tgt_mask,
  output logic                      tgt_none
);
  logic [AGENTS-1:0] addr_mask;
  logic [AGENTS-1:0] sel_mask;
  logic [AGENTS-1:0] low_mask;
  logic [AGENTS-1:0] next_mask;

  ipi_addr_decode #(.AGENTS(AGENTS), .ID_W(ID_W)) decode_i (
    .dest        (req_dest),
    .logical     (req_logical),
    .agent_lid   (agent_lid),
    .agent_model (agent_model),
    .addr_mask   (addr_mask)
  );

  ipi_shorthand_apply #(.AGENTS(AGENTS), .ID_W(ID_W)) short_i (
    .addr_mask (addr_mask),
    .shorthand (req_shorthand),
    .sender_id (sender_id),
    .agent_en  (agent_en),
    .sel_mask  (sel_mask)
  );

  ipi_lowest_pick #(.AGENTS(AGENTS)) pick_i (
    .mask_in (sel_mask),
    .pick    (low_mask)
  );

  assign next_mask = req_lowest ? low_mask : sel_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid <= 1'b0;
      tgt_mask  <= '0;
      tgt_none  <= 1'b0;
    end else begin
      tgt_valid <= req_valid;
      if (req_valid) begin
        tgt_mask <= next_mask;
        tgt_none <= ~|next_mask;
      end
    end
  end
endmodule

// File: rtl/ipi_dest_match_chk.sv
module ipi_dest_match_chk #(
  parameter int AGENTS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_shorthand,
  input logic              req_lowest,
  input logic [AGENTS-1:0] agent_en,
  input logic              tgt_valid,
  input logic [AGENTS-1:0] tgt_mask,
  input logic              tgt_none
);
  assert_reset_clear_R13: assert property (@(posedge clk)
    rst |=> (!tgt_valid && tgt_mask == '0 && !tgt_none));

  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> tgt_valid);

  assert_valid_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !tgt_valid);

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(tgt_mask) && $stable(tgt_none)));

  assert_enabled_only_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ((tgt_mask & ~$past(agent_en)) == '0));

  assert_none_flag_R11: assert property (@(posedge clk) disable iff (rst)
    tgt_valid |-> (tgt_none == (tgt_mask == '0)));

  assert_lowest_single_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lowest) |=> $onehot0(tgt_mask));

  assert_self_single_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_shorthand == 2'd1) |=> $onehot0(tgt_mask));
endmodule

bind ipi_dest_match ipi_dest_match_chk #(.AGENTS(AGENTS)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_shorthand (req_shorthand),
  .req_lowest    (req_lowest),
  .agent_en      (agent_en),
  .tgt_valid     (tgt_valid),
  .tgt_mask      (tgt_mask),
  .tgt_none      (tgt_none)
);

// File: tb/ipi_dest_match_tb_top.sv
module ipi_dest_match_tb_top;
  localparam int AGENTS = 8;
  localparam int ID_W   = 8;
  localparam int NV     = 18;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  req_valid = 1'b0;
  logic [ID_W-1:0]       req_dest = '0;
  logic                  req_logical = 1'b0;
  logic [1:0]            req_shorthand = '0;
  logic                  req_lowest = 1'b0;
  logic [ID_W-1:0]       sender_id = '0;
  logic [AGENTS-1:0]     agent_en = '1;
  logic [AGENTS*ID_W-1:0] agent_lid;
  logic [AGENTS*4-1:0]   agent_model;
  logic                  tgt_valid;
  logic [AGENTS-1:0]     tgt_mask;
  logic                  tgt_none;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  // Agents 0..3 flat (IDs 01,02,04,08); 4,5 cluster 3 (31,32);
  // 6 cluster 5 (51); 7 unsupported model 5 with ID FF.
  assign agent_lid   = {8'hFF, 8'h51, 8'h32, 8'h31, 8'h08, 8'h04, 8'h02, 8'h01};
  assign agent_model = {4'h5, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};

  ipi_dest_match #(.AGENTS(AGENTS), .ID_W(ID_W)) dut_i (
    .clk, .rst, .req_valid, .req_dest, .req_logical, .req_shorthand,
    .req_lowest, .sender_id, .agent_en, .agent_lid, .agent_model,
    .tgt_valid, .tgt_mask, .tgt_none
  );

  // {dest, logical, shorthand, lowest, sender, enable, exp_mask, exp_none}
  localparam logic [36:0] VECS [NV] = '{
    {8'hFF, 1'b0, 2'd0, 1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0},
    {8'h03, 1'b0, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h08, 1'b0},
    {8'h20, 1'b0, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b1},
    {8'h05, 1'b1, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h05, 1'b0},
    {8'h31, 1'b1, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h11, 1'b0},
    {8'h33, 1'b1, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h33, 1'b0},
    {8'h50, 1'b1, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b1},
    {8'hF0, 1'b1, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b1},
    {8'h00, 1'b0, 2'd1, 1'b0, 8'h05, 8'hFF, 8'h20, 1'b0},
    {8'h00, 1'b0, 2'd2, 1'b0, 8'h03, 8'hFF, 8'hFF, 1'b0},
    {8'h00, 1'b0, 2'd3, 1'b0, 8'h02, 8'hFF, 8'hFB, 1'b0},
    {8'h00, 1'b0, 2'd3, 1'b0, 8'h02, 8'h0F, 8'h0B, 1'b0},
    {8'h33, 1'b1, 2'd0, 1'b1, 8'h00, 8'hFF, 8'h01, 1'b0},
    {8'h33, 1'b1, 2'd0, 1'b1, 8'h00, 8'hFC, 8'h10, 1'b0},
    {8'hFF, 1'b0, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1},
    {8'h00, 1'b0, 2'd1, 1'b0, 8'h09, 8'hFF, 8'h00, 1'b1},
    {8'h00, 1'b0, 2'd3, 1'b1, 8'h00, 8'hFF, 8'h02, 1'b0},
    {8'h55, 1'b1, 2'd2, 1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0}
  };
  // Requirement named by each vector's checks.
  string tags [NV] = '{"R1", "R2", "R2", "R3", "R4", "R4", "R4", "R5",
                       "R6", "R7", "R8", "R10", "R9", "R9", "R10", "R6",
                       "R9", "R7"};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [36:0] v);
    @(negedge clk);
    req_dest      = v[36:29];
    req_logical   = v[28];
    req_shorthand = v[27:26];
    req_lowest    = v[25];
    sender_id     = v[24:17];
    agent_en      = v[16:9];
    req_valid     = 1'b1;
    @(negedge clk);
    req_valid     = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", "valid after reset", 32'(tgt_valid), 32'd0);
    check("R13", "mask after reset", 32'(tgt_mask), 32'd0);
    check("R13", "none after reset", 32'(tgt_none), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R12", "no valid without request", 32'(tgt_valid), 32'd0);

    for (int k = 0; k < NV; k++) begin
      send(VECS[k]);
      check(tags[k], $sformatf("vector %0d mask", k), 32'(tgt_mask), 32'(VECS[k][8:1]));
      check("R11", $sformatf("vector %0d none", k), 32'(tgt_none), 32'(VECS[k][0]));
      check("R12", $sformatf("vector %0d valid", k), 32'(tgt_valid), 32'd1);
    end

    // R12: hold without strobe while inputs change
    send({8'h33, 1'b1, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h33, 1'b0});
    req_dest = 8'hFF; req_logical = 1'b0; agent_en = 8'h00;
    repeat (3) @(negedge clk);
    check("R12", "mask held without request", 32'(tgt_mask), 32'h33);
    check("R12", "none held without request", 32'(tgt_none), 32'd0);
    check("R12", "valid low without request", 32'(tgt_valid), 32'd0);

    // R13: reset mid-run clears the held result
    rst = 1'b1;
    @(negedge clk);
    check("R13", "mask cleared by reset", 32'(tgt_mask), 32'd0);
    check("R13", "valid cleared by reset", 32'(tgt_valid), 32'd0);
    rst = 1'b0;

    // R10 + R9: lowest pick after all but the top agent disabled
    send({8'hFF, 1'b0, 2'd0, 1'b1, 8'h00, 8'h80, 8'h80, 1'b0});
    check("R9", "lowest among enabled", 32'(tgt_mask), 32'h80);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule